// File: doc/BRIEF.md
# ATM Cell Delineation State Machine

This block locks onto ATM cell boundaries using the per-cell outcome of a header check computed elsewhere. Once per 53-byte cell, a strobe carries two flags: whether the header checked clean and whether its single-bit error could be repaired. From these the block runs a hunt, presync and sync machine. It decides whether the outgoing cell data may be marked valid, enables single-bit repair only while the machine is locked or locking, and pulses start and clear controls to the external byte and cell counters.

The thresholds are asymmetric. Six accepted headers in a row promote presync to sync. Two invalid headers in a row drop presync back to hunt. Sync survives until seven invalid headers arrive in a row. Repaired headers count as accepted, but a repaired header that directly follows another repaired header is treated as invalid. The runs of accepted and invalid headers are counted inside the block, and each run restarts when the header type flips.

Top module: `cell_delin`

## Requirements
- R1: After reset, state_o is 0 (hunt), and data_valid, corr_en, cnt_start and cnt_clear are all 0.
- R2: In hunt (state_o 0), a strobed header with hdr_ok=1 moves state_o to 1 (presync) and pulses cnt_start for one cycle. A strobed header with hdr_ok=0 leaves the machine in hunt, whatever hdr_fixable is.
- R3: In presync, the sixth accepted header in an unbroken run moves state_o to 2 (sync). Fewer than six leave it at 1.
- R4: In presync and sync, a strobed header with hdr_ok=0 and hdr_fixable=1 counts as accepted, unless the header just before it was also accepted only through repair. In that case it counts as invalid.
- R5: In presync, one invalid header clears the accepted run, so six more accepted headers are needed. A second consecutive invalid header returns state_o to 0 and pulses cnt_clear for one cycle.
- R6: In sync, the seventh consecutive invalid header returns state_o to 0 and pulses cnt_clear. Any accepted header restarts that run.
- R7: data_valid is 1 only in presync or sync, and is 0 whenever the two or more most recent headers were consecutive invalid ones. It returns to 1 on the next accepted header.
- R8: corr_en is 1 exactly while state_o is 1 or 2.
- R9: hdr_ok and hdr_fixable have no effect in any cycle where hdr_stb is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_stb | input | 1 | One-cycle strobe at each cell boundary |
| hdr_ok | input | 1 | Header check passed |
| hdr_fixable | input | 1 | Header has a repairable single-bit error |
| state_o | output | 2 | 0 hunt, 1 presync, 2 sync, 3 unused |
| data_valid | output | 1 | Cell data may be used |
| corr_en | output | 1 | Single-bit repair allowed |
| cnt_start | output | 1 | Pulse: start external byte/cell counting |
| cnt_clear | output | 1 | Pulse: clear external byte/cell counters |

## Verification
Every output is due one clock after the rising edge that samples the strobe: state_o, data_valid and corr_en settle there, and the start and clear pulses last exactly that one cycle. The bench drives each strobe on a falling edge, drops it on the next falling edge, and reads all outputs at that moment, inside the cycle the pulse occupies. It then checks on a later falling edge that the pulse is gone. Threshold checks read the state both after the header one short of the limit and after the header at the limit.

// File: rtl/cell_delin.sv
module cell_delin #(
  parameter int PRE_N     = 6,
  parameter int PRE_LOSS  = 2,
  parameter int SYNC_LOSS = 7,
  parameter int BLANK_N   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hdr_stb,
  input  logic       hdr_ok,
  input  logic       hdr_fixable,
  output logic [1:0] state_o,
  output logic       data_valid,
  output logic       corr_en,
  output logic       cnt_start,
  output logic       cnt_clear
);
  localparam int M1   = (PRE_N > SYNC_LOSS) ? PRE_N : SYNC_LOSS;
  localparam int M2   = (PRE_LOSS > BLANK_N) ? PRE_LOSS : BLANK_N;
  localparam int MAXN = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXN + 1);

  typedef enum logic [1:0] {HUNT = 2'd0, PRESYNC = 2'd1, SYNC = 2'd2, ILLEGAL = 2'd3} st_t;

  st_t           state, st_n;
  logic [CW-1:0] good_cnt, good_n, bad_cnt, bad_n;
  logic          prev_fix, pf_n, start_n, clear_n;

  wire           locked   = (state == PRESYNC) || (state == SYNC);
  wire           fixed    = !hdr_ok && hdr_fixable && locked && !prev_fix;
  wire           hdr_good = hdr_ok || fixed;
  wire [CW-1:0]  good_nx  = good_cnt + 1'b1;
  wire [CW-1:0]  bad_nx   = bad_cnt + 1'b1;

  always_comb begin
    st_n    = state;
    good_n  = good_cnt;
    bad_n   = bad_cnt;
    pf_n    = prev_fix;
    start_n = 1'b0;
    clear_n = 1'b0;
    case (state)
      HUNT: begin
        good_n = '0;
        bad_n  = '0;
        pf_n   = 1'b0;
        if (hdr_stb && hdr_ok) begin
          st_n    = PRESYNC;
          start_n = 1'b1;
        end
      end
      PRESYNC: if (hdr_stb) begin
        if (hdr_good) begin
          bad_n = '0;
          pf_n  = fixed;
          if (good_nx == CW'(PRE_N)) begin
            st_n   = SYNC;
            good_n = '0;
          end else begin
            good_n = good_nx;
          end
        end else begin
          good_n = '0;
          pf_n   = 1'b0;
          if (bad_nx == CW'(PRE_LOSS)) begin
            st_n    = HUNT;
            bad_n   = '0;
            clear_n = 1'b1;
          end else begin
            bad_n = bad_nx;
          end
        end
      end
      SYNC: if (hdr_stb) begin
        good_n = '0;
        if (hdr_good) begin
          bad_n = '0;
          pf_n  = fixed;
        end else begin
          pf_n = 1'b0;
          if (bad_nx == CW'(SYNC_LOSS)) begin
            st_n    = HUNT;
            bad_n   = '0;
            clear_n = 1'b1;
          end else begin
            bad_n = bad_nx;
          end
        end
      end
      default: begin
        st_n   = HUNT;
        good_n = '0;
        bad_n  = '0;
        pf_n   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= HUNT;
      good_cnt  <= '0;
      bad_cnt   <= '0;
      prev_fix  <= 1'b0;
      cnt_start <= 1'b0;
      cnt_clear <= 1'b0;
    end else begin
      state     <= st_n;
      good_cnt  <= good_n;
      bad_cnt   <= bad_n;
      prev_fix  <= pf_n;
      cnt_start <= start_n;
      cnt_clear <= clear_n;
    end
  end

  assign state_o    = state;
  assign corr_en    = locked;
  assign data_valid = locked && (bad_cnt < CW'(BLANK_N));
endmodule

module cell_delin_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hdr_stb,
  input logic       hdr_ok,
  input logic [1:0] state_o,
  input logic       data_valid,
  input logic       corr_en,
  input logic       cnt_start,
  input logic       cnt_clear
);
  // R2
  hunt_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_stb && hdr_ok && state_o == 2'd0) |=> (state_o == 2'd1 && cnt_start));

  // R9
  no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hdr_stb && state_o != 2'd3) |=> $stable(state_o));

  // R3
  sync_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2 && $past(state_o) != 2'd2) |-> ($past(state_o) == 2'd1 && $past(hdr_stb)));

  // R6
  sync_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2 && hdr_stb && hdr_ok) |=> (state_o == 2'd2 && data_valid));

  // R5
  clear_in_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |-> (state_o == 2'd0 && !cnt_start));

  // R7
  hunt_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0) |-> (!data_valid && !corr_en));
endmodule

bind cell_delin cell_delin_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hdr_stb(hdr_stb), .hdr_ok(hdr_ok),
  .state_o(state_o), .data_valid(data_valid), .corr_en(corr_en),
  .cnt_start(cnt_start), .cnt_clear(cnt_clear)
);

// File: tb/cell_delin_tb.sv
`timescale 1ns/1ps
module cell_delin_tb;
  logic clk = 1'b0;
  logic rst_n, hdr_stb, hdr_ok, hdr_fixable;
  logic [1:0] state_o;
  logic data_valid, corr_en, cnt_start, cnt_clear;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  cell_delin u_dut (
    .clk(clk), .rst_n(rst_n), .hdr_stb(hdr_stb), .hdr_ok(hdr_ok),
    .hdr_fixable(hdr_fixable), .state_o(state_o), .data_valid(data_valid),
    .corr_en(corr_en), .cnt_start(cnt_start), .cnt_clear(cnt_clear)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; hdr_stb = 1'b0; hdr_ok = 1'b0; hdr_fixable = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(input logic ok, input logic fix);
    @(negedge clk);
    hdr_stb = 1'b1; hdr_ok = ok; hdr_fixable = fix;
    @(negedge clk);
    hdr_stb = 1'b0; hdr_ok = 1'b0; hdr_fixable = 1'b0;
  endtask

  task automatic go_sync();
    do_reset();
    send(1'b1, 1'b0);
    for (int i = 0; i < 6; i++) send(1'b1, 1'b0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 state", state_o, 0);
    chk("R1 data_valid", data_valid, 0);
    chk("R1 corr_en", corr_en, 0);
    chk("R1 pulses", {cnt_start, cnt_clear}, 0);
  endtask

  task automatic t_hunt();
    do_reset();
    send(1'b0, 1'b1);
    chk("R2 fixable stays hunt", state_o, 0);
    chk("R8 corr_en in hunt", corr_en, 0);
    send(1'b0, 1'b0);
    chk("R2 bad stays hunt", state_o, 0);
    send(1'b1, 1'b0);
    chk("R2 enter presync", state_o, 1);
    chk("R2 cnt_start pulse", cnt_start, 1);
    chk("R8 corr_en presync", corr_en, 1);
    chk("R7 valid presync", data_valid, 1);
    @(negedge clk);
    chk("R2 cnt_start one cycle", cnt_start, 0);
  endtask

  task automatic t_to_sync();
    do_reset();
    send(1'b1, 1'b0);
    for (int i = 0; i < 5; i++) send(1'b1, 1'b0);
    chk("R3 five accepted stay presync", state_o, 1);
    send(1'b1, 1'b0);
    chk("R3 sixth accepted enters sync", state_o, 2);
    chk("R8 corr_en sync", corr_en, 1);
  endtask

  task automatic t_presync_loss();
    do_reset();
    send(1'b1, 1'b0);
    for (int i = 0; i < 3; i++) send(1'b1, 1'b0);
    send(1'b0, 1'b0);
    chk("R5 single bad stays presync", state_o, 1);
    chk("R7 single bad keeps valid", data_valid, 1);
    for (int i = 0; i < 5; i++) send(1'b1, 1'b0);
    chk("R5 run cleared by bad", state_o, 1);
    send(1'b1, 1'b0);
    chk("R5 sync after fresh run", state_o, 2);
    do_reset();
    send(1'b1, 1'b0);
    send(1'b0, 1'b0);
    send(1'b0, 1'b0);
    chk("R5 two bad to hunt", state_o, 0);
    chk("R5 cnt_clear pulse", cnt_clear, 1);
    chk("R7 hunt blanks", data_valid, 0);
    @(negedge clk);
    chk("R5 cnt_clear one cycle", cnt_clear, 0);
  endtask

  task automatic t_fixed();
    do_reset();
    send(1'b1, 1'b0);
    for (int i = 0; i < 3; i++) begin
      send(1'b0, 1'b1);
      send(1'b1, 1'b0);
    end
    chk("R4 repaired count as valid", state_o, 2);
    do_reset();
    send(1'b1, 1'b0);
    send(1'b0, 1'b1);
    send(1'b0, 1'b1);
    chk("R4 second repair invalid stays presync", state_o, 1);
    send(1'b0, 1'b0);
    chk("R4 repeated repair counted invalid", state_o, 0);
  endtask

  task automatic t_sync_loss();
    go_sync();
    send(1'b0, 1'b0);
    chk("R7 one bad valid", data_valid, 1);
    send(1'b0, 1'b0);
    chk("R7 two bad blank", data_valid, 0);
    for (int i = 0; i < 4; i++) send(1'b0, 1'b0);
    chk("R6 six bad stay sync", state_o, 2);
    send(1'b0, 1'b1);
    chk("R7 repaired restores valid", data_valid, 1);
    for (int i = 0; i < 6; i++) send(1'b0, 1'b0);
    chk("R6 run restarted", state_o, 2);
    send(1'b0, 1'b0);
    chk("R6 seventh bad to hunt", state_o, 0);
    chk("R6 cnt_clear pulse", cnt_clear, 1);
    chk("R8 corr_en off", corr_en, 0);
  endtask

  task automatic t_ignore();
    go_sync();
    @(negedge clk);
    hdr_ok = 1'b0; hdr_fixable = 1'b1;
    repeat (20) @(negedge clk);
    chk("R9 sync unaffected", state_o, 2);
    chk("R9 valid unaffected", data_valid, 1);
    do_reset();
    hdr_ok = 1'b1;
    repeat (10) @(negedge clk);
    chk("R9 hunt unaffected", state_o, 0);
    chk("R9 no start", cnt_start, 0);
    hdr_ok = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hdr_stb = 1'b0; hdr_ok = 1'b0; hdr_fixable = 1'b0;
    t_reset();
    t_hunt();
    t_to_sync();
    t_presync_loss();
    t_fixed();
    t_sync_loss();
    t_ignore();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule